// File: doc/BRIEF.md
# Parallel FIR Filter with Switchable Coefficient Sets

This block is a fully parallel finite impulse response filter. Every tap has its own multiplier, so all products for an input sample are formed in the same cycle and then summed. The result is presented at full precision: the output is wide enough to hold any sum of products, and nothing is rounded or dropped along the way.

The filter holds several constant coefficient sets, given as a parameter table. Switching between them takes two steps. A select index chooses a set through a per-tap multiplexer, but the taps keep using their current coefficients. A separate load strobe then copies the selected set into the per-tap coefficient registers. This lets the select path settle ahead of time, while the strobe marks the exact sample at which the filter changes character. The select input is expected to be stable for at least four cycles before the strobe is raised.

An elaboration-time option puts two register stages on every input, which keeps heavy fan-out away from the driving logic. The cost is two extra cycles of latency, and the results are otherwise the same.

Top module: `fir_switchable`

## Requirements
- R1: `dout` is DW+CW+$clog2(TAPS) bits wide (18 with the defaults) and carries the exact two's-complement sum of products. Extremes such as four products of (-128)·(-128) = 65536 appear unclipped.
- R2: For each accepted sample x[n], `dout` equals the sum over tap i of c[i]·x[n-i], where c[i] is the active coefficient for tap i and x[n-i] counts only accepted samples. Samples older than reset count as zero. Coefficient i of set s is the signed CW-bit field at bit offset (s·TAPS+i)·CW of `COEF_TABLE`.
- R3: A change on `set_sel` alone, with no `set_load`, leaves the active coefficients unchanged.
- R4: When `set_load` is high, the set indexed by `set_sel` becomes active. A sample accepted in the same cycle as the load still uses the old set, and samples accepted after it use the new set.
- R5: `dout_vld` pulses exactly once per accepted sample, 2 clock cycles after the cycle in which `din_vld` was high.
- R6: While `din_vld` is low, the sample history does not shift and no output is produced.
- R7: While synchronous reset `rst` is high, `dout` is cleared to 0 and `dout_vld` to 0, the sample history is cleared, and set 0 is made active whatever `set_sel` holds.
- R8: With `REG_IN`=1, all inputs pass through two register stages. Outputs are identical to the `REG_IN`=0 case, delayed by 2 more cycles (4 in total).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DW | Signed input sample |
| din_vld | input | 1 | Input sample valid |
| set_sel | input | $clog2(NSETS) | Coefficient set index (takes effect on load) |
| set_load | input | 1 | Load strobe: makes the selected set active |
| dout | output | DW+CW+$clog2(TAPS) | Signed full-precision filter output |
| dout_vld | output | 1 | Output valid |

## Verification
The interesting coincidence is a coefficient load in the same cycle as an accepted sample. The design must then use the old set for that sample and the new set for the next one. The bench provokes this by raising `set_load` together with `din_vld` in the middle of a pseudo-random stream. It judges the result sample by sample against a convolution model whose active set switches only after the sample of the load cycle has been scored. A second collision, a reset arriving while `set_sel` points to a non-zero set, is judged by an impulse that must reproduce set 0 with no leftover history.

// File: rtl/fir_sw_pkg.sv
package fir_sw_pkg;
  // Full-precision width of a sum of n products of dw x cw signed operands
  function automatic int unsigned sum_width(int unsigned dw, int unsigned cw, int unsigned n);
    return dw + cw + $clog2(n);
  endfunction
endpackage

// File: rtl/fir_sw_coefbank.sv
module fir_sw_coefbank #(
  parameter int unsigned CW    = 8,
  parameter int unsigned TAPS  = 4,
  parameter int unsigned NSETS = 3,
  parameter int unsigned SW    = (NSETS > 1) ? $clog2(NSETS) : 1,
  parameter logic [NSETS*TAPS*CW-1:0] TABLE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        sel,
  input  logic                 load,
  output logic [TAPS*CW-1:0]   ctap
);
  localparam int unsigned SETW = TAPS * CW;

  function automatic logic [SETW-1:0] set_bits(input logic [SW-1:0] s);
    if (int'(s) < int'(NSETS)) return TABLE[int'(s)*SETW +: SETW];
    else                       return TABLE[SETW-1:0];
  endfunction

  logic [SETW-1:0] picked;

  // Per-tap set multiplexer; its output reaches the taps only on load
  always_comb picked = set_bits(sel);

  always_ff @(posedge clk) begin
    if (rst)       ctap <= TABLE[SETW-1:0];
    else if (load) ctap <= picked;
  end

  // R3
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ctap));

  // R4
  coef_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (ctap == set_bits($past(sel))));
endmodule

// File: rtl/fir_sw_macarr.sv
module fir_sw_macarr #(
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 8,
  parameter int unsigned TAPS = 4,
  parameter int unsigned OW   = DW + CW + $clog2(TAPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      x,
  input  logic               x_vld,
  input  logic [TAPS*CW-1:0] ctap,
  output logic [OW-1:0]      y,
  output logic               y_vld
);
  localparam int unsigned PW = DW + CW;
  localparam int unsigned HN = (TAPS > 1) ? TAPS - 1 : 1;
  localparam longint      MAXV = longint'(TAPS) <<< (PW - 2);

  logic [HN-1:0][DW-1:0]  hist;
  logic signed [DW-1:0]   win  [TAPS];
  logic signed [CW-1:0]   cof  [TAPS];
  logic signed [PW-1:0]   prod_q [TAPS];
  logic                   prod_vld;
  logic signed [OW-1:0]   acc;

  assign win[0] = $signed(x);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign cof[t] = $signed(ctap[t*CW +: CW]);
    if (t > 0) begin : g_hist
      assign win[t] = $signed(hist[t-1]);
    end
  end

  // History of accepted samples: shifts only on valid input
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (x_vld) begin
      hist[0] <= x;
      for (int i = 1; i < int'(HN); i++) hist[i] <= hist[i-1];
    end
  end

  // Stage 1: all products in parallel
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_vld <= 1'b0;
      for (int t = 0; t < int'(TAPS); t++) prod_q[t] <= '0;
    end else begin
      prod_vld <= x_vld;
      if (x_vld)
        for (int t = 0; t < int'(TAPS); t++) prod_q[t] <= win[t] * cof[t];
    end
  end

  // Stage 2: full-precision sum, registered output
  always_comb begin
    acc = '0;
    for (int t = 0; t < int'(TAPS); t++)
      acc = acc + {{(OW-PW){prod_q[t][PW-1]}}, prod_q[t]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y     <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= prod_vld;
      if (prod_vld) y <= acc;
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    y_vld |-> (longint'($signed(y)) <= MAXV && longint'($signed(y)) >= -MAXV));

  // R6
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !x_vld |=> $stable(hist));

  // R5
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    y_vld |-> $past(x_vld, 2));
endmodule

// File: rtl/fir_switchable.sv
module fir_switchable #(
  parameter int unsigned DW     = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned TAPS   = 4,
  parameter int unsigned NSETS  = 3,
  parameter bit          REG_IN = 1'b0,
  parameter int unsigned SW     = (NSETS > 1) ? $clog2(NSETS) : 1,
  parameter int unsigned OW     = fir_sw_pkg::sum_width(DW, CW, TAPS),
  parameter logic [NSETS*TAPS*CW-1:0] COEF_TABLE = {
    8'hB3, 8'h00, 8'hFF, 8'h7F,
    8'h80, 8'h80, 8'h80, 8'h80,
    8'h04, 8'h03, 8'h02, 8'h01 }
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          din_vld,
  input  logic [SW-1:0] set_sel,
  input  logic          set_load,
  output logic [OW-1:0] dout,
  output logic          dout_vld
);
  localparam int unsigned IW = DW + SW + 2;

  logic [IW-1:0]        raw_in, use_in;
  logic [DW-1:0]        x;
  logic                 x_vld;
  logic [SW-1:0]        sel;
  logic                 load;
  logic [TAPS*CW-1:0]   ctap;

  assign raw_in = {din, set_sel, din_vld, set_load};

  if (REG_IN) begin : g_inreg
    logic [IW-1:0] stg1, stg2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stg1 <= '0;
        stg2 <= '0;
      end else begin
        stg1 <= raw_in;
        stg2 <= stg1;
      end
    end
    assign use_in = stg2;
  end else begin : g_direct
    assign use_in = raw_in;
  end

  assign {x, sel, x_vld, load} = use_in;

  fir_sw_coefbank #(
    .CW(CW), .TAPS(TAPS), .NSETS(NSETS), .SW(SW), .TABLE(COEF_TABLE)
  ) u_bank (
    .clk(clk), .rst(rst), .sel(sel), .load(load), .ctap(ctap)
  );

  fir_sw_macarr #(
    .DW(DW), .CW(CW), .TAPS(TAPS), .OW(OW)
  ) u_mac (
    .clk(clk), .rst(rst), .x(x), .x_vld(x_vld), .ctap(ctap),
    .y(dout), .y_vld(dout_vld)
  );
endmodule

// File: tb/fir_switchable_tb.sv
`timescale 1ns/1ps
module fir_switchable_tb;
  localparam int DW = 8, CW = 8, TAPS = 4, NSETS = 3, SW = 2, OW = 18;
  localparam int MAXE = 2048;

  // Coefficients per set and tap, written independently of the RTL table
  int cset [NSETS][TAPS] = '{ '{1, 2, 3, 4},
                              '{-128, -128, -128, -128},
                              '{127, -1, 0, -77} };

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic din_vld = 1'b0, set_load = 1'b0;
  logic [SW-1:0] set_sel = '0;
  logic [OW-1:0] dout, dout_r;
  logic dout_vld, dout_vld_r;

  always #2 clk = ~clk;

  fir_switchable #(.REG_IN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .set_sel(set_sel),
    .set_load(set_load), .dout(dout), .dout_vld(dout_vld));

  fir_switchable #(.REG_IN(1'b1)) u_dut_r (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .set_sel(set_sel),
    .set_load(set_load), .dout(dout_r), .dout_vld(dout_vld_r));

  int nchk = 0, nfail = 0, cyc = 0;
  int hist [TAPS];
  int act = 0, wp = 0, rp0 = 0, rp1 = 0;
  int    exp_val [MAXE];
  int    exp_cyc [MAXE];
  string exp_req [MAXE];
  string cur_req = "R2";
  bit done = 1'b0;
  int seed = 7;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input int act_v, input int exp_v);
    nchk++;
    if (act_v !== exp_v) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act_v, exp_v);
    end
  endtask

  // One cycle of stimulus plus model update
  task automatic step(input bit v, input int x, input int s, input bit ld);
    int e;
    @(negedge clk);
    din = DW'(x); din_vld = v; set_sel = SW'(s); set_load = ld;
    if (v) begin
      for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      e = 0;
      for (int i = 0; i < TAPS; i++) e += cset[act][i] * hist[i];
      exp_val[wp] = e; exp_cyc[wp] = cyc; exp_req[wp] = cur_req; wp++;
    end
    if (ld) act = s;
  endtask

  task automatic idle(input int n, input int s);
    for (int k = 0; k < n; k++) step(1'b0, 0, s, 1'b0);
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst = 1'b1; din_vld = 1'b0; set_load = 1'b0; set_sel = SW'(s);
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    act = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_set(input int s);
    idle(4, s);
    step(1'b0, 0, s, 1'b1);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  // Output monitor for both instances
  always @(negedge clk) begin
    if (!rst) begin
      if (dout_vld) begin
        if (rp0 >= wp) chk("R5 extra output", 1, 0);
        else begin
          chk(exp_req[rp0], int'($signed(dout)), exp_val[rp0]);
          chk("R5 latency", cyc - exp_cyc[rp0], 2);
          rp0++;
        end
      end
      if (dout_vld_r) begin
        if (rp1 >= wp) chk("R8 extra output", 1, 0);
        else begin
          chk("R8", int'($signed(dout_r)), exp_val[rp1]);
          chk("R8 latency", cyc - exp_cyc[rp1], 4);
          rp1++;
        end
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    // R7: reset with a non-zero set selected
    do_reset(1);
    @(negedge clk);
    chk("R7 dout", int'(dout), 0);
    chk("R7 dout_vld", int'(dout_vld), 0);
    cur_req = "R7";
    step(1'b1, 1, 1, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 0, 1, 1'b0);
    // R3: select moves without a load; set 0 must stay active
    cur_req = "R3";
    idle(5, 2);
    step(1'b1, 1, 2, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 0, 2, 1'b0);
    // R4: load lands on a valid sample in mid-stream
    cur_req = "R4";
    for (int k = 0; k < 5; k++) step(1'b1, rnd(), 2, 1'b0);
    step(1'b1, rnd(), 2, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b1, rnd(), 2, 1'b0);
    // R4: re-load of the same set changes nothing
    step(1'b1, rnd(), 2, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b1, rnd(), 2, 1'b0);
    // R1: extreme products, full-width sum
    cur_req = "R1";
    load_set(1);
    for (int k = 0; k < 6; k++) step(1'b1, -128, 1, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, 127, 1, 1'b0);
    load_set(2);
    for (int k = 0; k < 6; k++) step(1'b1, -128, 2, 1'b0);
    // R6: sparse valid pattern
    cur_req = "R6";
    for (int k = 0; k < 40; k++) step((k % 3) != 1, rnd(), 2, 1'b0);
    // R2: every set, impulse then full input sweep
    cur_req = "R2";
    for (int s = 0; s < NSETS; s++) begin
      load_set(s);
      step(1'b1, 1, s, 1'b0);
      for (int v = -128; v < 128; v++) step(1'b1, v, s, 1'b0);
    end
    // R7: mid-run reset clears history and restores set 0
    idle(6, 2);
    do_reset(2);
    @(negedge clk);
    chk("R7 dout", int'(dout), 0);
    chk("R7 dout_vld", int'(dout_vld), 0);
    cur_req = "R7";
    step(1'b1, -3, 2, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 0, 2, 1'b0);
    idle(8, 2);
    chk("R5 output count", rp0, wp);
    chk("R8 output count", rp1, wp);
    done = 1'b1;
    report();
  end
endmodule